// File: doc/BRIEF.md
# Early-Assert Late-Release FIFO Status Flag

This block produces a single FIFO status flag, either "full" or "empty", in the clock domain that consumes it. It compares two one-hot ring pointers: a local pointer that steps on the destination clock, and a remote pointer that steps on the other side's clock. The comparison is made on the position the local pointer will hold after the current edge. A flag caused by local movement therefore appears in the same cycle as the pointer state it guards, after a single register.

The two directions of a flag change are handled differently. A raw condition can only become true through the local pointer, so that change is synchronous and is captured by one flop. It can only become false through the remote pointer, so that change is asynchronous and must pass through a synchronizing chain before the flag is allowed to drop. The flag may assert early, when the FIFO is only about to reach the guarded state. An early assertion is harmless and only postpones the release.

One instance with the empty kind sits in the read domain: its local pointer is the read pointer and its remote pointer is the write pointer. One instance with the full kind sits in the write domain, with the roles swapped. The full kind fires at DEPTH-1 stored entries, so that the case of equal pointers always means empty.

Top module: `status_flag_detector`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `flag` is 1 for the empty kind (KIND=0) and 0 for the full kind (KIND=1). The reset takes effect without waiting for a clock edge.
- R2: Pointers are one-hot over DEPTH bits. One advance moves the token from bit i to bit (i+1) mod DEPTH, wrapping from bit DEPTH-1 to bit 0. `localAdv`=1 means the local pointer advances at this edge, and the condition is evaluated on that next position.
- R3: For the empty kind, the condition is true when the next local position equals the remote position.
- R4: For the full kind, the condition is true when the next local position plus one, mod DEPTH, equals the remote position. This corresponds to DEPTH-1 stored entries.
- R5: If the condition is true at a clock edge, `flag` is 1 in the cycle after that edge.
- R6: `flag` drops only after the condition has been false at RELEASE_EDGES consecutive edges. Once that has happened, `flag` is 0.
- R7: `flag` is never 0 in a cycle in which the registered local pointer (the current `localPtr`) and `remotePtr` satisfy the condition.
- R8: `flag` never rises unless the condition was true at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rstN | input | 1 | Destination reset, active low, already synchronized on release |
| localPtr | input | DEPTH | Current one-hot pointer of the destination domain |
| localAdv | input | 1 | Local pointer advances at this edge |
| remotePtr | input | DEPTH | One-hot pointer from the other clock domain |
| flag | output | 1 | Full or empty flag, depending on KIND |

## Verification
A wrong release chain shows as a flag that drops one or more cycles too soon after a remote move. In a real FIFO that means an access to a slot that is still occupied or still empty, and it is visible within RELEASE_EDGES cycles. A wrong comparator or a wrong rotation direction shows in the cycle after the local pointer lands on the guarded position: the flag stays low while the pointers already satisfy the relation. The wrap from the top bit to bit zero is exercised explicitly. A randomized read/write traffic phase keeps an occupancy count and confirms that the flags never let that count leave the range 0 to DEPTH-1.

// File: rtl/flagdet_pkg.sv
package flagdet_pkg;

  // Which status the detector produces; also selects its reset value.
  typedef enum logic {
    FLAG_EMPTY = 1'b0,
    FLAG_FULL  = 1'b1
  } flagKind_e;

  // Strobes handed from the comparator datapath to the flag control.
  typedef struct packed {
    logic hitNext;   // raw condition on the local pointer's next position
  } cmpStrobe_t;

endpackage

// File: rtl/flagdet_cmp.sv
// Comparator datapath: forms the next local position and tests it
// against the remote pointer with one AND per ring slot.
module flagdet_cmp
  import flagdet_pkg::*;
#(
  parameter int        DEPTH = 7,
  parameter flagKind_e KIND  = FLAG_EMPTY
) (
  input  logic [DEPTH-1:0] localPtr,
  input  logic             localAdv,
  input  logic [DEPTH-1:0] remotePtr,
  output cmpStrobe_t       strobe
);

  logic [DEPTH-1:0] stepped;
  logic [DEPTH-1:0] localNext;
  logic [DEPTH-1:0] target;
  logic [DEPTH-1:0] slotMatch;

  // Token moves from bit i to bit i+1, top bit wraps to bit 0.
  assign stepped   = {localPtr[DEPTH-2:0], localPtr[DEPTH-1]};
  assign localNext = localAdv ? stepped : localPtr;

  generate
    if (KIND == FLAG_FULL) begin : gFullTarget
      // Full when the remote sits one slot ahead of the next local slot.
      assign target = {localNext[DEPTH-2:0], localNext[DEPTH-1]};
    end else begin : gEmptyTarget
      assign target = localNext;
    end
  endgenerate

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : gSlot
      assign slotMatch[i] = target[i] & remotePtr[i];
    end
  endgenerate

  assign strobe.hitNext = |slotMatch;

endmodule

// File: rtl/flagdet_ctl.sv
// Flag control: one register for the synchronous rise, a short chain
// that holds the flag until a falling raw condition has been resampled.
module flagdet_ctl
  import flagdet_pkg::*;
#(
  parameter int        RELEASE_EDGES = 2,
  parameter flagKind_e KIND          = FLAG_EMPTY
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t strobe,
  output logic       flag
);

  localparam int   CHAIN_LEN = RELEASE_EDGES - 1;
  localparam logic RST_VAL   = (KIND == FLAG_EMPTY);

  logic [CHAIN_LEN-1:0] holdChain;
  logic                 flagQ;

  generate
    if (CHAIN_LEN == 1) begin : gChainOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) holdChain <= RST_VAL;
        else       holdChain <= strobe.hitNext;
      end
    end else begin : gChainMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) holdChain <= {CHAIN_LEN{RST_VAL}};
        else       holdChain <= {holdChain[CHAIN_LEN-2:0], strobe.hitNext};
      end
    end
  endgenerate

  // Rise comes straight from the raw condition; fall needs every
  // chain stage to have seen the condition false.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= RST_VAL;
    else       flagQ <= strobe.hitNext | (|holdChain);
  end

  assign flag = flagQ;

endmodule

// File: rtl/status_flag_detector.sv
module status_flag_detector
  import flagdet_pkg::*;
#(
  parameter int        DEPTH         = 7,
  parameter int        RELEASE_EDGES = 2,
  parameter flagKind_e KIND          = FLAG_EMPTY
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] localPtr,
  input  logic             localAdv,
  input  logic [DEPTH-1:0] remotePtr,
  output logic             flag
);

  cmpStrobe_t cmpStrobe;

  flagdet_cmp #(
    .DEPTH (DEPTH),
    .KIND  (KIND)
  ) uCmp (
    .localPtr  (localPtr),
    .localAdv  (localAdv),
    .remotePtr (remotePtr),
    .strobe    (cmpStrobe)
  );

  flagdet_ctl #(
    .RELEASE_EDGES (RELEASE_EDGES),
    .KIND          (KIND)
  ) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (cmpStrobe),
    .flag   (flag)
  );

endmodule

// File: rtl/flagdet_chk.sv
module flagdet_chk
  import flagdet_pkg::*;
#(
  parameter int        DEPTH         = 7,
  parameter int        RELEASE_EDGES = 2,
  parameter flagKind_e KIND          = FLAG_EMPTY
) (
  input logic             clk,
  input logic             rstN,
  input logic [DEPTH-1:0] localPtr,
  input logic             localAdv,
  input logic [DEPTH-1:0] remotePtr,
  input logic             flag
);

  localparam logic RST_VAL = (KIND == FLAG_EMPTY);
  localparam int   QW      = $clog2(RELEASE_EDGES + 1) + 1;

  function automatic logic [DEPTH-1:0] step(input logic [DEPTH-1:0] p);
    return {p[DEPTH-2:0], p[DEPTH-1]};
  endfunction

  function automatic logic related(input logic [DEPTH-1:0] loc,
                                   input logic [DEPTH-1:0] rem);
    if (KIND == FLAG_FULL) return step(loc) == rem;
    else                   return loc == rem;
  endfunction

  logic condNext;
  logic condNow;
  assign condNext = related(localAdv ? step(localPtr) : localPtr, remotePtr);
  assign condNow  = related(localPtr, remotePtr);

  // Consecutive edges with the condition false, saturating.
  logic [QW-1:0] quietCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         quietCnt <= '0;
    else if (condNext)                 quietCnt <= '0;
    else if (quietCnt < QW'(RELEASE_EDGES)) quietCnt <= quietCnt + 1'b1;
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    $rose(rstN) |-> flag == RST_VAL);

  assert_raise_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    condNext |=> flag);

  assert_release_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> quietCnt >= QW'(RELEASE_EDGES));

  assert_release_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt >= QW'(RELEASE_EDGES) |-> !flag);

  assert_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    condNow |-> flag);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(condNext));

endmodule

bind status_flag_detector flagdet_chk #(
  .DEPTH         (DEPTH),
  .RELEASE_EDGES (RELEASE_EDGES),
  .KIND          (KIND)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .localPtr  (localPtr),
  .localAdv  (localAdv),
  .remotePtr (remotePtr),
  .flag      (flag)
);

// File: tb/sim_status_flag_detector.sv
`timescale 1ns/1ps
module sim_status_flag_detector;
  import flagdet_pkg::*;

  localparam int D    = 7;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rstN;
  logic [D-1:0] eLocal, eRemote, fLocal, fRemote;
  logic eAdv, fAdv;
  logic eFlag, fFlag;

  int total  = 0;
  int failed = 0;

  always #4 clk = ~clk;   // 125 MHz

  // Empty kind: local = read pointer, remote = write pointer.
  status_flag_detector #(.DEPTH(D), .RELEASE_EDGES(2), .KIND(FLAG_EMPTY)) u0 (
    .clk(clk), .rstN(rstN), .localPtr(eLocal), .localAdv(eAdv),
    .remotePtr(eRemote), .flag(eFlag));

  // Full kind: local = write pointer, remote = read pointer.
  status_flag_detector #(.DEPTH(D), .RELEASE_EDGES(2), .KIND(FLAG_FULL)) u1 (
    .clk(clk), .rstN(rstN), .localPtr(fLocal), .localAdv(fAdv),
    .remotePtr(fRemote), .flag(fFlag));

  // Columns: eLoc, eAdv, eRem, eExp, fLoc, fAdv, fRem, fExp
  localparam int VEC [NVEC][8] = '{
    '{0,0,0,1, 0,0,0,0},
    '{0,0,1,1, 0,1,0,0},
    '{0,0,1,0, 1,1,0,0},
    '{0,0,2,0, 2,1,0,0},
    '{0,1,2,0, 3,1,0,0},
    '{1,1,2,1, 4,1,0,0},
    '{2,0,2,1, 5,1,0,1},
    '{2,0,3,1, 6,0,0,1},
    '{2,0,3,0, 6,0,1,1},
    '{2,1,3,1, 6,0,1,0},
    '{3,0,4,1, 6,1,1,1},
    '{3,0,5,0, 0,0,2,1},
    '{3,1,6,0, 0,0,3,0},
    '{4,1,6,0, 0,1,3,0},
    '{5,1,6,1, 1,0,3,0},
    '{6,0,0,1, 1,1,3,1},
    '{6,0,0,0, 2,0,3,1},
    '{6,1,0,1, 2,0,3,1},
    '{0,0,0,1, 2,0,4,1}
  };
  localparam string ETAG [NVEC] = '{"R3","R6","R6","R8","R3","R5","R7","R6","R6","R5",
                                    "R6","R6","R8","R2","R5","R6","R6","R2","R3"};
  localparam string FTAG [NVEC] = '{"R1","R4","R4","R4","R4","R4","R5","R7","R6","R6",
                                    "R2","R6","R6","R8","R8","R4","R7","R7","R6"};

  function automatic logic [D-1:0] oneHot(input int idx);
    return (D)'(1) << idx;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int wrIdx, rdIdx, count;
    logic wrEn, rdEn;
    rstN = 1'b0;
    eLocal = oneHot(0); eRemote = oneHot(0); eAdv = 1'b0;
    fLocal = oneHot(0); fRemote = oneHot(0); fAdv = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "empty flag in reset", eFlag, 1'b1);
    chk("R1", "full flag in reset", fFlag, 1'b0);
    @(negedge clk) rstN = 1'b1;

    // Table walk: drive on the falling edge, sample 2 ns after the rising edge.
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      eLocal  = oneHot(VEC[k][0]); eAdv = 1'(VEC[k][1]); eRemote = oneHot(VEC[k][2]);
      fLocal  = oneHot(VEC[k][4]); fAdv = 1'(VEC[k][5]); fRemote = oneHot(VEC[k][6]);
      @(posedge clk);
      #2;
      chk(ETAG[k], $sformatf("empty row %0d", k), eFlag, 1'(VEC[k][3]));
      chk(FTAG[k], $sformatf("full row %0d", k),  fFlag, 1'(VEC[k][7]));
    end

    // Reset in the middle of a run, with the full flag high: R1.
    @(negedge clk);
    eLocal = oneHot(0); eRemote = oneHot(0); eAdv = 1'b0;
    fLocal = oneHot(0); fRemote = oneHot(0); fAdv = 1'b0;
    rstN = 1'b0;
    #1;
    chk("R1", "full flag cleared without clock", fFlag, 1'b0);
    chk("R1", "empty flag set without clock", eFlag, 1'b1);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #2;
    chk("R1", "empty flag first cycle after reset", eFlag, 1'b1);
    chk("R1", "full flag first cycle after reset", fFlag, 1'b0);

    // Random traffic on one shared ring: flags must keep occupancy legal (R7).
    wrIdx = 0; rdIdx = 0; count = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      wrEn = !fFlag && ($urandom_range(0, 99) < ((c / 500) % 2 == 0 ? 70 : 30));
      rdEn = !eFlag && ($urandom_range(0, 99) < ((c / 500) % 2 == 0 ? 30 : 70));
      eLocal = oneHot(rdIdx); eAdv = rdEn; eRemote = oneHot(wrIdx);
      fLocal = oneHot(wrIdx); fAdv = wrEn; fRemote = oneHot(rdIdx);
      @(posedge clk);
      #2;
      if (wrEn) wrIdx = (wrIdx + 1) % D;
      if (rdEn) rdIdx = (rdIdx + 1) % D;
      count = count + int'(wrEn) - int'(rdEn);
      eLocal = oneHot(rdIdx); eAdv = 1'b0; eRemote = oneHot(wrIdx);
      fLocal = oneHot(wrIdx); fAdv = 1'b0; fRemote = oneHot(rdIdx);
      if (count == 0)     chk("R7", "empty flag with no entries", eFlag, 1'b1);
      if (count == D - 1) chk("R7", "full flag at DEPTH-1 entries", fFlag, 1'b1);
      if (count < 0 || count > D - 1) chk("R7", "occupancy within range", 1'b0, 1'b1);
    end

    finishRun();
  end

endmodule